// File: doc/BRIEF.md
# Static Wear Leveler

This block watches a stream of block erase events and decides when rarely erased (cold) blocks should be forcibly reclaimed. Physical blocks are grouped in runs of 2^k consecutive addresses, and each group has one flag bit. The block keeps a running count of every erase since the flags were last cleared, and a count of how many groups have a set flag. When the erases concentrate on too few groups, it picks a group whose flag is still clear and asks an external cleaner to reclaim it.

The unevenness test compares the total erase count against the threshold times the number of flagged groups, so no divider is needed. The cleaner is asked through a valid/ready request carrying the group index. After an accepted request the test is held off until an erase landing in the requested group has been counted. When the test fires but every group is already flagged, the flags and both counts are cleared, and the search position jumps to a pseudo-random group taken from an internal 16-bit LFSR.

Top module: `wl_static_leveler`

## Requirements
- R1: The group of an erased block is its address shifted right by `kShift`. There are 2^(BLK_W-kShift) groups, and `reqGroup` is always below that count.
- R2: Every erase event adds one to the erase count. An erase in a group whose flag is clear sets that flag and adds one to the flagged-group count.
- R3: From the idle state, when the flagged-group count is non-zero, the erase count is at least `thresh` times the flagged-group count, and some flag is clear, the block searches forward from its current position, wrapping at the group count, and requests the first group with a clear flag.
- R4: No request is raised while the flagged-group count is zero, even when `thresh` is 0.
- R5: When the R3 condition holds but every flag is set, the flags and both counts are cleared, the search position moves to an LFSR-derived group, no request is raised, and counting restarts from zero.
- R6: `reqValid` stays high with a stable `reqGroup` until `reqReady` is sampled high. It drops in the following cycle, and only one request is outstanding at a time.
- R7: Erase events that arrive while a request is pending are still counted.
- R8: After a request is accepted, no new request is raised until an erase inside the requested group has been counted.
- R9: An erase presented in the same cycle as the clear of R5 is counted into the new interval: its group is flagged and both counts become 1.
- R10: After reset `reqValid` is 0, all flags and counts are 0, and the search position is group 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| eraseValid | input | 1 | One erase event in this cycle |
| eraseBlk | input | BLK_W | Physical address of the erased block |
| kShift | input | KW | Log2 of the number of blocks per group, clamped to BLK_W |
| thresh | input | TW | Unevenness threshold T |
| reqValid | output | 1 | Clean request pending |
| reqReady | input | 1 | Cleaner accepts the request |
| reqGroup | output | BLK_W | Group index to reclaim |

## Verification
Two functions of this block can fall in the same cycle: the idle-state clear of the flags and counts, and the counting of a fresh erase event. The bench provokes this by sending the cleaner's erase of the last clear group and, in the very next cycle, a second erase into another group. The first erase fills the flags and meets the ratio, so the clear happens exactly when the second erase arrives. The outcome is judged at the request port: only if the second erase survived the clear do the counts meet a threshold of 1. The one clear group is then requested, whatever the random search position.

// File: rtl/wl_pkg.sv
package wl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_REQ,
    ST_WAIT
  } wl_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAll;    // wipe flags and counters
    logic loadRand;  // move search position to random group
    logic stepSel;   // advance search position by one (wrapping)
  } wl_strobe_t;

  // status from datapath to control
  typedef struct packed {
    logic trigger;   // ratio test met and flagged count non-zero
    logic allSet;    // every active group flagged
    logic selFlag;   // flag of group under search position
    logic hitTarget; // erase this cycle lands in selected group
  } wl_status_t;

endpackage

// File: rtl/wl_datapath.sv
module wl_datapath
  import wl_pkg::*;
#(
  parameter int BLK_W = 8,
  parameter int TW    = 16,
  parameter int EW    = 24,
  parameter int KW    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             eraseValid,
  input  logic [BLK_W-1:0] eraseBlk,
  input  logic [KW-1:0]    kShift,
  input  logic [TW-1:0]    thresh,
  input  wl_strobe_t       stb,
  output wl_status_t       status,
  output logic [BLK_W-1:0] selIdx,
  output logic [BLK_W:0]   fcntQ,
  output logic [EW-1:0]    ecntQ,
  output logic [BLK_W:0]   numGroups
);

  localparam int NG = 1 << BLK_W;
  localparam int FW = BLK_W + 1;
  localparam int PW = TW + FW;
  localparam int CW = (EW > PW) ? EW : PW;
  localparam logic [KW-1:0] K_MAX = KW'(BLK_W);
  localparam logic [15:0] LFSR_SEED = 16'hACE1;

  logic [KW-1:0]    kEff;
  logic [BLK_W-1:0] groupMask;
  logic [BLK_W-1:0] eraseGrp;
  logic [NG-1:0]    flags;
  logic [15:0]      lfsr;
  logic             isNew;
  logic [EW-1:0]    ecntBase;
  logic [FW-1:0]    fcntBase;
  logic [PW-1:0]    bar;

  assign kEff      = (kShift > K_MAX) ? K_MAX : kShift;
  assign numGroups = FW'(1) << (K_MAX - kEff);
  assign groupMask = BLK_W'(numGroups - FW'(1));
  assign eraseGrp  = eraseBlk >> kEff;

  // an erase is new to the interval if its flag is clear or being wiped
  assign isNew    = eraseValid && (stb.clrAll || !flags[eraseGrp]);
  assign ecntBase = stb.clrAll ? '0 : ecntQ;
  assign fcntBase = stb.clrAll ? '0 : fcntQ;

  assign bar = PW'(thresh) * PW'(fcntQ);

  assign status.trigger   = (fcntQ != '0) && (CW'(ecntQ) >= CW'(bar));
  assign status.allSet    = (fcntQ == numGroups);
  assign status.selFlag   = flags[selIdx];
  assign status.hitTarget = eraseValid && (eraseGrp == selIdx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flags  <= '0;
      ecntQ  <= '0;
      fcntQ  <= '0;
      selIdx <= '0;
      lfsr   <= LFSR_SEED;
    end else begin
      lfsr  <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      flags <= (stb.clrAll ? '0 : flags) | (isNew ? (NG'(1) << eraseGrp) : '0);
      ecntQ <= (eraseValid && (ecntBase != '1)) ? ecntBase + EW'(1) : ecntBase;
      fcntQ <= isNew ? fcntBase + FW'(1) : fcntBase;
      if (stb.loadRand)
        selIdx <= BLK_W'(lfsr) & groupMask;
      else if (stb.stepSel)
        selIdx <= (selIdx + BLK_W'(1)) & groupMask;
    end
  end

endmodule

// File: rtl/wl_control.sv
module wl_control
  import wl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  wl_status_t status,
  input  logic       reqReady,
  output wl_strobe_t stb,
  output logic       reqValid,
  output logic       waiting
);

  wl_state_t state, stateNext;

  always_comb begin
    stateNext = state;
    stb       = '0;
    case (state)
      ST_IDLE: begin
        if (status.trigger) begin
          if (status.allSet) begin
            stb.clrAll   = 1'b1;
            stb.loadRand = 1'b1;
          end else begin
            stateNext = ST_SCAN;
          end
        end
      end
      ST_SCAN: begin
        if (status.allSet)
          stateNext = ST_IDLE;
        else if (!status.selFlag)
          stateNext = ST_REQ;
        else
          stb.stepSel = 1'b1;
      end
      ST_REQ: begin
        if (reqReady)
          stateNext = ST_WAIT;
      end
      ST_WAIT: begin
        if (status.hitTarget)
          stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      state <= ST_IDLE;
    else
      state <= stateNext;
  end

  assign reqValid = (state == ST_REQ);
  assign waiting  = (state == ST_WAIT);

endmodule

// File: rtl/wl_static_leveler.sv
module wl_static_leveler
  import wl_pkg::*;
#(
  parameter int BLK_W = 8,
  parameter int TW    = 16,
  parameter int EW    = 24,
  localparam int KW   = $clog2(BLK_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             eraseValid,
  input  logic [BLK_W-1:0] eraseBlk,
  input  logic [KW-1:0]    kShift,
  input  logic [TW-1:0]    thresh,
  output logic             reqValid,
  input  logic             reqReady,
  output logic [BLK_W-1:0] reqGroup
);

  wl_strobe_t       stb;
  wl_status_t       status;
  logic [BLK_W-1:0] selIdx;
  logic [BLK_W:0]   fcntQ;
  logic [EW-1:0]    ecntQ;
  logic [BLK_W:0]   numGroups;
  logic             waiting;
  logic             clrAll;
  logic             hitTarget;

  wl_datapath #(.BLK_W(BLK_W), .TW(TW), .EW(EW), .KW(KW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .eraseValid(eraseValid),
    .eraseBlk  (eraseBlk),
    .kShift    (kShift),
    .thresh    (thresh),
    .stb       (stb),
    .status    (status),
    .selIdx    (selIdx),
    .fcntQ     (fcntQ),
    .ecntQ     (ecntQ),
    .numGroups (numGroups)
  );

  wl_control u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .status  (status),
    .reqReady(reqReady),
    .stb     (stb),
    .reqValid(reqValid),
    .waiting (waiting)
  );

  assign reqGroup  = selIdx;
  assign clrAll    = stb.clrAll;
  assign hitTarget = status.hitTarget;

endmodule

// File: rtl/wl_checker.sv
module wl_checker #(
  parameter int BLK_W = 8,
  parameter int EW    = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic [BLK_W-1:0] reqGroup,
  input logic [BLK_W:0]   fcntQ,
  input logic [EW-1:0]    ecntQ,
  input logic [BLK_W:0]   numGroups,
  input logic             clrAll,
  input logic             waiting,
  input logic             hitTarget
);

  a_r6_hold_request: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady |=> reqValid && $stable(reqGroup));

  a_r6_single_request: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqValid);

  a_r4_no_req_when_empty: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> fcntQ != '0);

  a_r1_group_in_range: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> ({1'b0, reqGroup} < numGroups));

  a_r2_flag_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    fcntQ <= numGroups);

  a_r5_clear_restarts: assert property (@(posedge clk) disable iff (!rstN)
    clrAll |=> (ecntQ <= EW'(1)) && (fcntQ <= (BLK_W+1)'(1)));

  a_r8_hold_off: assert property (@(posedge clk) disable iff (!rstN)
    waiting && !hitTarget |=> !reqValid);

endmodule

bind wl_static_leveler wl_checker #(.BLK_W(BLK_W), .EW(EW)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .reqGroup (reqGroup),
  .fcntQ    (fcntQ),
  .ecntQ    (ecntQ),
  .numGroups(numGroups),
  .clrAll   (clrAll),
  .waiting  (waiting),
  .hitTarget(hitTarget)
);

// File: tb/wl_static_leveler_bench.sv
`timescale 1ns/1ps
module wl_static_leveler_bench;

  localparam int BLK_W = 8;
  localparam int KW    = $clog2(BLK_W + 1);

  typedef struct packed {
    logic [7:0] blk;
    logic       useLast;
    logic       expReq;
    logic [3:0] mask;   // bit g set: group g acceptable
  } vec_t;

  // k = 6 (four groups of 64 blocks), thresh = 3, search starts at group 0
  localparam vec_t VEC [16] = '{
    '{8'd5,   1'b0, 1'b0, 4'b0000},  // e1 f1
    '{8'd10,  1'b0, 1'b0, 4'b0000},  // e2 f1
    '{8'd70,  1'b0, 1'b0, 4'b0000},  // e3 f2
    '{8'd1,   1'b0, 1'b0, 4'b0000},  // e4
    '{8'd2,   1'b0, 1'b0, 4'b0000},  // e5
    '{8'd3,   1'b0, 1'b1, 4'b0100},  // e6 >= 6 -> group 2
    '{8'd130, 1'b0, 1'b0, 4'b0000},  // cleaner erase, e7 f3
    '{8'd4,   1'b0, 1'b0, 4'b0000},  // e8
    '{8'd5,   1'b0, 1'b1, 4'b1000},  // e9 >= 9 -> group 3
    '{8'd200, 1'b0, 1'b0, 4'b0000},  // e10 f4 all set
    '{8'd0,   1'b0, 1'b0, 4'b0000},  // e11
    '{8'd0,   1'b0, 1'b0, 4'b0000},  // e12 >= 12, all set -> clear
    '{8'd64,  1'b0, 1'b0, 4'b0000},  // e1 f1
    '{8'd64,  1'b0, 1'b0, 4'b0000},  // e2
    '{8'd64,  1'b0, 1'b1, 4'b1101},  // e3 >= 3 -> any clear group
    '{8'd0,   1'b1, 1'b0, 4'b0000}   // cleaner erase of that group, e4 f2
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             eraseValid = 1'b0;
  logic [BLK_W-1:0] eraseBlk = '0;
  logic [KW-1:0]    kShift = KW'(6);
  logic [15:0]      thresh = 16'd0;
  logic             reqReady = 1'b0;
  logic             reqValid;
  logic [BLK_W-1:0] reqGroup;

  int checks = 0;
  int failures = 0;
  int lastGrp = 0;

  always #4 clk = ~clk;

  wl_static_leveler #(.BLK_W(BLK_W)) u_wl_static_leveler (
    .clk       (clk),
    .rstN      (rstN),
    .eraseValid(eraseValid),
    .eraseBlk  (eraseBlk),
    .kShift    (kShift),
    .thresh    (thresh),
    .reqValid  (reqValid),
    .reqReady  (reqReady),
    .reqGroup  (reqGroup)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset(input int k, input int t);
    @(negedge clk);
    rstN = 1'b0;
    kShift = KW'(k);
    thresh = 16'(t);
    idle(3);
    rstN = 1'b1;
  endtask

  task automatic erase(input int blk);
    @(negedge clk);
    eraseValid = 1'b1;
    eraseBlk = BLK_W'(blk);
    @(negedge clk);
    eraseValid = 1'b0;
  endtask

  task automatic erasePair(input int a, input int b);
    @(negedge clk);
    eraseValid = 1'b1;
    eraseBlk = BLK_W'(a);
    @(negedge clk);
    eraseBlk = BLK_W'(b);
    @(negedge clk);
    eraseValid = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk);
    reqReady = 1'b1;
    @(negedge clk);
    reqReady = 1'b0;
  endtask

  task automatic expectReq(input string tag, input int grp);
    idle(10);
    check(reqValid && (int'(reqGroup) == grp), tag,
          reqValid ? int'(reqGroup) : -1, grp);
  endtask

  task automatic expectNone(input string tag);
    idle(10);
    check(!reqValid, tag, int'(reqValid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R10: reset state
    idle(2);
    check(!reqValid, "R10 reset reqValid", int'(reqValid), 0);
    rstN = 1'b1;
    // R4: thresh 0 with no flagged groups must not request
    expectNone("R4 empty bitmap, thresh 0");

    // table walk
    doReset(6, 3);
    for (int i = 0; i < 16; i++) begin
      string tag;
      int blk;
      tag = VEC[i].expReq ? "R3" : ((i >= 11) ? "R5" : "R2");
      blk = VEC[i].useLast ? (lastGrp << 6) : int'(VEC[i].blk);
      erase(blk);
      idle(10);
      if (VEC[i].expReq) begin
        check(reqValid && (reqGroup < 4) && VEC[i].mask[reqGroup[1:0]], tag,
              reqValid ? int'(reqGroup) : -1, int'(VEC[i].mask));
        lastGrp = int'(reqGroup);
        ack();
      end else begin
        check(!reqValid, tag, int'(reqValid), 0);
      end
    end

    // R6 R7 R8 R10: pending request, erases while waiting
    doReset(6, 2);
    erase(0);
    erase(0);
    expectReq("R10 search starts at group 0", 1);
    erase(128);
    erase(128);
    idle(2);
    check(reqValid && (reqGroup == 1), "R6 request held without ack",
          reqValid ? int'(reqGroup) : -1, 1);
    ack();
    idle(1);
    check(!reqValid, "R6 request drops after ack", int'(reqValid), 0);
    erase(64);                       // cleaner erase of group 1: e5 f3
    expectNone("R8 below ratio after cleaner erase");
    erase(0);                        // e6 >= 6 only if pending erases counted
    expectReq("R7 erases during pending request counted", 3);
    ack();
    erase(0);
    erase(0);
    erase(0);                        // ratio holds, target not yet erased
    expectNone("R8 no re-evaluation before target erase");
    erase(192);                      // e10 f4 all set -> clear
    expectNone("R5 clear raises no request");
    erase(0);
    erase(0);                        // e2 f1 >= 2 in the new interval
    idle(10);
    check(reqValid && (reqGroup != 0) && (reqGroup < 4), "R5 counting restarted",
          reqValid ? int'(reqGroup) : -1, 1);
    ack();

    // R1 R9: k = 7 (two groups of 128), thresh 1
    doReset(7, 1);
    erase(100);                      // group 0 under k=7
    expectReq("R1 block 100 maps to group 0", 1);
    ack();
    erasePair(200, 50);              // second erase lands on the clear cycle
    expectReq("R9 erase on clear cycle counted", 1);
    ack();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule